// File: doc/BRIEF.md
# Single-Precision Round-to-Integral Unit

This unit takes one binary32 floating-point operand and a two-bit rounding direction. It returns the nearest integral value in that direction, still encoded as binary32, together with an invalid flag and an inexact flag. It does not convert the value to an integer format. Special operands pass through or are quieted. Subnormal operands are flushed to a zero that keeps the input's sign. Normal operands with magnitude of 2^23 or more are already integral and come back unchanged.

For all other normal operands the unit splits the significand at the binary point. It forms a round bit and a sticky bit from the discarded fraction and applies the chosen direction. It then renormalises the integer magnitude and puts back the input sign. The result is registered: an operand presented with `in_valid` high appears on the outputs one clock later, with `out_valid` high.

Top module: `fp32_round_integral`

## Requirements
- R1: After reset, with `rst` high, `out_valid`, `out_result`, `out_invalid` and `out_inexact` are all zero.
- R2: `out_valid` equals `in_valid` from one cycle earlier. Result and flags load only in a cycle where `in_valid` is high, exactly one cycle after that cycle, and otherwise hold their values.
- R3: A signalling NaN has exponent field 255, a nonzero fraction and fraction bit 22 clear. It returns the operand with fraction bit 22 set, `out_invalid`=1 and `out_inexact`=0.
- R4: A quiet NaN (exponent 255, fraction bit 22 set), an infinity (exponent 255, fraction 0) or a zero (exponent 0, fraction 0) returns the operand bit for bit, with both flags 0.
- R5: A subnormal operand (exponent 0, fraction nonzero) returns a zero carrying the operand's sign bit, with both flags 0.
- R6: A normal operand with exponent field 150 to 254 returns the operand bit for bit, with both flags 0.
- R7: A normal operand with exponent field below 126 has integer part 0, round bit 0 and sticky bit 1. The result is the signed zero, except that direction 2 on a positive operand gives +1.0 (0x3F800000) and direction 3 on a negative operand gives -1.0 (0xBF800000).
- R8: Direction code 0 rounds to nearest with ties to even. It increments the integer part when the round bit is set and either the sticky bit is set or the integer part is odd.
- R9: Direction code 1 rounds toward zero and never increments the integer part.
- R10: Direction code 2 increments the integer part when round or sticky is set and the operand is positive. Direction code 3 does the same only when the operand is negative.
- R11: For normal operands with exponent field below 150, `out_inexact` is 1 exactly when any fraction bit below the binary point was nonzero, whatever the direction. `out_invalid` is 0 on that path.
- R12: The result sign bit always equals the operand sign bit, so a negative operand that rounds to zero yields -0 (0x80000000).
- R13: The integer magnitude is re-encoded with exponent field 127 plus the position of its leading one, with the bits below that one as the fraction. A zero magnitude gives a signed zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand and direction are valid this cycle |
| in_operand | input | 32 | binary32 operand |
| in_mode | input | 2 | Rounding direction: 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| out_valid | output | 1 | Result registers were loaded on the previous edge |
| out_result | output | 32 | Rounded integral value in binary32 |
| out_invalid | output | 1 | Signalling NaN operand seen |
| out_inexact | output | 1 | Discarded fraction was nonzero |

## Verification
The assertions assume that `in_valid`, `in_operand` and `in_mode` are always known values. They also assume these inputs change only away from the rising edge, so the registered outputs can be related to the inputs of the previous cycle. The bench drives every input on the falling edge and holds it there, and it never leaves a bit undriven after reset. It sweeps all 256 exponent fields against both signs, all four directions and a set of fractions that includes exact halves, near-halves and all-ones patterns. The expected value for each case comes from integer division and remainder.

// File: rtl/fp32ri_pkg.sv
package fp32ri_pkg;

    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    // integer magnitude may reach 2^FRAC_W after an increment
    localparam int MAG_W  = FRAC_W + 1;
    localparam int POS_W  = $clog2(MAG_W);
    // exponent field from which every operand is already integral
    localparam int INTEGRAL_EXP = BIAS + FRAC_W;
    // below this exponent field the magnitude is under one half
    localparam int HALF_EXP = BIAS - 1;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'd0,
        RM_ZERO    = 2'd1,
        RM_UP      = 2'd2,
        RM_DOWN    = 2'd3
    } rmode_t;

    typedef enum logic [2:0] {
        CL_ZERO,
        CL_SUB,
        CL_NORM,
        CL_INF,
        CL_QNAN,
        CL_SNAN
    } opclass_t;

    typedef struct packed {
        logic [MAG_W-1:0] whole;
        logic             rnd;
        logic             stk;
    } split_t;

    function automatic logic [POS_W-1:0] top_one(input logic [MAG_W-1:0] v);
        logic [POS_W-1:0] p;
        p = '0;
        for (int i = 0; i < MAG_W; i++) begin
            if (v[i]) p = POS_W'(i);
        end
        return p;
    endfunction

endpackage

// File: rtl/fp32ri_classify.sv
module fp32ri_classify
    import fp32ri_pkg::*;
(
    input  logic [WORD_W-1:0] operand,
    output opclass_t          cls,
    output logic              integral
);
    logic [EXP_W-1:0]  ef;
    logic [FRAC_W-1:0] ff;

    assign ef = operand[WORD_W-2 -: EXP_W];
    assign ff = operand[FRAC_W-1:0];

    always_comb begin
        if (ef == '1) begin
            if (ff == '0)            cls = CL_INF;
            else if (ff[FRAC_W-1])   cls = CL_QNAN;
            else                     cls = CL_SNAN;
        end else if (ef == '0) begin
            cls = (ff == '0) ? CL_ZERO : CL_SUB;
        end else begin
            cls = CL_NORM;
        end
    end

    assign integral = (ef >= EXP_W'(INTEGRAL_EXP));

endmodule

// File: rtl/fp32ri_split.sv
module fp32ri_split
    import fp32ri_pkg::*;
(
    input  logic [EXP_W-1:0]  ef,
    input  logic [FRAC_W-1:0] ff,
    output split_t            parts
);
    logic [MAG_W-1:0]   mant;
    logic [EXP_W:0]     sh;
    logic [2*MAG_W-1:0] ext;
    logic               tiny;

    assign mant = {1'b1, ff};
    assign tiny = (ef < EXP_W'(HALF_EXP));
    assign sh   = (EXP_W+1)'(INTEGRAL_EXP) - {1'b0, ef};
    assign ext  = {mant, {MAG_W{1'b0}}} >> sh;

    always_comb begin
        if (tiny) begin
            parts.whole = '0;
            parts.rnd   = 1'b0;
            parts.stk   = 1'b1;
        end else begin
            parts.whole = ext[2*MAG_W-1:MAG_W];
            parts.rnd   = ext[MAG_W-1];
            parts.stk   = |ext[MAG_W-2:0];
        end
    end

endmodule

// File: rtl/fp32ri_decide.sv
module fp32ri_decide
    import fp32ri_pkg::*;
(
    input  split_t           parts,
    input  logic             sign,
    input  rmode_t           mode,
    output logic [MAG_W-1:0] mag,
    output logic             inexact
);
    logic lost;
    logic bump;

    assign lost = parts.rnd | parts.stk;

    always_comb begin
        unique case (mode)
            RM_NEAREST: bump = parts.rnd & (parts.stk | parts.whole[0]);
            RM_ZERO:    bump = 1'b0;
            RM_UP:      bump = lost & ~sign;
            RM_DOWN:    bump = lost & sign;
            default:    bump = 1'b0;
        endcase
    end

    assign mag     = parts.whole + MAG_W'(bump);
    assign inexact = lost;

endmodule

// File: rtl/fp32ri_pack.sv
module fp32ri_pack
    import fp32ri_pkg::*;
(
    input  logic [MAG_W-1:0]  mag,
    input  logic              sign,
    output logic [WORD_W-1:0] word
);
    logic [POS_W-1:0]  lead;
    logic [POS_W-1:0]  lsh;
    logic [EXP_W-1:0]  ef;
    logic [FRAC_W-1:0] ff;

    assign lead = top_one(mag);
    assign lsh  = POS_W'(FRAC_W) - lead;
    assign ef   = EXP_W'(BIAS) + EXP_W'(lead);
    assign ff   = FRAC_W'(mag << lsh);

    always_comb begin
        if (mag == '0) word = {sign, {(WORD_W-1){1'b0}}};
        else           word = {sign, ef, ff};
    end

endmodule

// File: rtl/fp32_round_integral.sv
module fp32_round_integral
    import fp32ri_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_operand,
    input  logic [1:0]        in_mode,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_result,
    output logic              out_invalid,
    output logic              out_inexact
);
    opclass_t          cls;
    logic              integral;
    split_t            parts;
    logic [MAG_W-1:0]  mag;
    logic              lost;
    logic [WORD_W-1:0] packed_word;
    logic              sgn;

    logic [WORD_W-1:0] nxt_res;
    logic              nxt_inv;
    logic              nxt_inx;

    assign sgn = in_operand[WORD_W-1];

    fp32ri_classify u_cls (
        .operand  (in_operand),
        .cls      (cls),
        .integral (integral)
    );

    fp32ri_split u_split (
        .ef    (in_operand[WORD_W-2 -: EXP_W]),
        .ff    (in_operand[FRAC_W-1:0]),
        .parts (parts)
    );

    fp32ri_decide u_dec (
        .parts   (parts),
        .sign    (sgn),
        .mode    (rmode_t'(in_mode)),
        .mag     (mag),
        .inexact (lost)
    );

    fp32ri_pack u_pack (
        .mag  (mag),
        .sign (sgn),
        .word (packed_word)
    );

    always_comb begin
        nxt_res = in_operand;
        nxt_inv = 1'b0;
        nxt_inx = 1'b0;
        unique case (cls)
            CL_SNAN: begin
                nxt_res            = in_operand;
                nxt_res[FRAC_W-1]  = 1'b1;
                nxt_inv            = 1'b1;
            end
            CL_SUB: nxt_res = {sgn, {(WORD_W-1){1'b0}}};
            CL_NORM: begin
                if (!integral) begin
                    nxt_res = packed_word;
                    nxt_inx = lost;
                end
            end
            default: nxt_res = in_operand;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_result  <= '0;
            out_invalid <= 1'b0;
            out_inexact <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result  <= nxt_res;
                out_invalid <= nxt_inv;
                out_inexact <= nxt_inx;
            end
        end
    end

endmodule

// File: rtl/fp32ri_checker.sv
module fp32ri_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] in_operand,
    input logic [1:0]  in_mode,
    input logic        out_valid,
    input logic [31:0] out_result,
    input logic        out_invalid,
    input logic        out_inexact
);
    // R2: valid follows one cycle later
    a_r2_valid_delay: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r2_valid_drop: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R2: outputs hold when nothing new is presented
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_result) && $stable(out_inexact) && $stable(out_invalid)));
    // R3: invalid only ever accompanies a quiet NaN result
    a_r3_invalid_qnan: assert property (@(posedge clk) disable iff (rst)
        out_invalid |-> (out_result[30:23] == 8'hFF && out_result[22]));
    // R11: the two flags never rise together
    a_r11_flags_apart: assert property (@(posedge clk) disable iff (rst)
        !(out_invalid && out_inexact));
    // R12: sign carried through
    a_r12_sign: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_result[31] == $past(in_operand[31]));
    // R6: large normal operands pass untouched
    a_r6_passthru: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_operand[30:23] >= 8'd150 && in_operand[30:23] != 8'hFF)
        |=> (out_result == $past(in_operand) && !out_inexact));
    // R9: toward zero never grows the magnitude
    a_r9_no_growth: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'd1 && in_operand[30:23] != 8'hFF)
        |=> out_result[30:0] <= $past(in_operand[30:0]));
endmodule

bind fp32_round_integral fp32ri_checker u_chk (.*);

// File: tb/fp32_round_integral_test.sv
module fp32_round_integral_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] in_operand;
    logic [1:0]  in_mode;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_invalid;
    logic        out_inexact;

    int n_cmp = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    fp32_round_integral uut (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_operand  (in_operand),
        .in_mode     (in_mode),
        .out_valid   (out_valid),
        .out_result  (out_result),
        .out_invalid (out_invalid),
        .out_inexact (out_inexact)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp,
                       input logic [31:0] op);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s op=%h mode=%0d actual=%h expected=%h", tag, op, in_mode, act, exp);
        end
    endtask

    // reference model: integer division and remainder
    task automatic model(input logic [31:0] op, input logic [1:0] md,
                         output logic [31:0] res, output logic inv, output logic inx,
                         output string tag);
        logic        s;
        int          e;
        longint      f, mant, den, q, r, half;
        logic        gt, eq, nz, up;
        s = op[31]; e = int'(op[30:23]); f = longint'(op[22:0]);
        inv = 1'b0; inx = 1'b0;
        if (e == 255 && f != 0 && !op[22]) begin
            res = op | 32'h0040_0000; inv = 1'b1; tag = "R3"; return;
        end
        if (e == 255 || (e == 0 && f == 0)) begin
            res = op; tag = "R4"; return;
        end
        if (e == 0) begin
            res = {s, 31'b0}; tag = "R5"; return;
        end
        if (e >= 150) begin
            res = op; tag = "R6"; return;
        end
        mant = 64'd8388608 + f;
        if (e < 126) begin
            q = 0; gt = 1'b0; eq = 1'b0; nz = 1'b1; tag = "R7";
        end else begin
            den  = 64'd1 << (150 - e);
            q    = mant / den;
            r    = mant % den;
            half = den / 2;
            gt = r > half; eq = r == half; nz = r != 0;
            tag = (md == 2'd0) ? "R8" : (md == 2'd1) ? "R9" : "R10";
        end
        case (md)
            2'd0: up = gt || (eq && q[0]);
            2'd1: up = 1'b0;
            2'd2: up = nz && !s;
            default: up = nz && s;
        endcase
        if (up) q = q + 1;
        inx = nz;
        if (q == 0) begin
            res = {s, 31'b0};
        end else begin
            int b;
            b = 0;
            for (int k = 0; k < 25; k++) if (q >= (64'd1 << k)) b = k;
            res = {s, 8'(127 + b), 23'((q - (64'd1 << b)) << (23 - b))};
        end
    endtask

    task automatic apply(input logic [31:0] op, input logic [1:0] md);
        logic [31:0] er;
        logic        ei, ex;
        string       tg;
        @(negedge clk);
        in_valid = 1'b1; in_operand = op; in_mode = md;
        model(op, md, er, ei, ex, tg);
        @(negedge clk);
        in_valid = 1'b0;
        chk(tg, out_result, er, op);
        chk("R11", {31'b0, out_inexact}, {31'b0, ex}, op);
        chk("R3_invalid", {31'b0, out_invalid}, {31'b0, ei}, op);
        chk("R12", {31'b0, out_result[31]}, {31'b0, op[31]}, op);
        chk("R2", {31'b0, out_valid}, 32'd1, op);
    endtask

    initial begin : watchdog
        repeat (180000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] lfsr;
        logic [22:0] fr [14];
        rst = 1'b1; in_valid = 1'b0; in_operand = '0; in_mode = '0;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", out_result, 32'h0, 32'h0);
        chk("R1", {29'b0, out_valid, out_invalid, out_inexact}, 32'h0, 32'h0);
        rst = 1'b0;

        // R13 directed: 2.5 nearest -> 2.0, 3.5 nearest -> 4.0, 0.5 up -> 1.0
        apply(32'h4020_0000, 2'd0); chk("R13", out_result, 32'h4000_0000, 32'h4020_0000);
        apply(32'h4060_0000, 2'd0); chk("R13", out_result, 32'h4080_0000, 32'h4060_0000);
        apply(32'h3F00_0000, 2'd2); chk("R7", out_result, 32'h3F80_0000, 32'h3F00_0000);
        apply(32'hBF00_0000, 2'd0); chk("R12", out_result, 32'h8000_0000, 32'hBF00_0000);
        apply(32'h4B7F_FFFF, 2'd2); chk("R13", out_result, 32'h4B7F_FFFF, 32'h4B7F_FFFF);

        // R2: hold when in_valid is low
        @(negedge clk);
        in_valid = 1'b0; in_operand = 32'h7F80_0001; in_mode = 2'd0;
        @(negedge clk);
        chk("R2_hold", out_result, 32'h4B7F_FFFF, 32'h7F80_0001);
        chk("R2_valid", {31'b0, out_valid}, 32'd0, 32'h7F80_0001);

        fr[0] = 23'h000000; fr[1] = 23'h000001; fr[2] = 23'h400000; fr[3] = 23'h3FFFFF;
        fr[4] = 23'h7FFFFF; fr[5] = 23'h200000; fr[6] = 23'h600000; fr[7] = 23'h000100;
        fr[8] = 23'h7FFF00; fr[9] = 23'h100001; fr[10] = 23'h555555; fr[11] = 23'h0C0000;
        fr[12] = 23'h300000; fr[13] = 23'h2AAAAA;
        lfsr = 32'hACE1_2345;
        for (int md = 0; md < 4; md++) begin
            for (int sg = 0; sg < 2; sg++) begin
                for (int e = 0; e < 256; e++) begin
                    for (int k = 0; k < 14; k++) begin
                        apply({sg[0], e[7:0], fr[k]}, md[1:0]);
                    end
                    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                    apply({sg[0], e[7:0], lfsr[22:0]}, md[1:0]);
                end
            end
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule